// File: doc/BRIEF.md
# Configuration Cycle Address Translator

This block looks at the address phase of a Type 1 configuration cycle that arrives from the upstream bus. It picks one of four outcomes. The cycle can become a Type 0 cycle for the local secondary bus. It can be passed further downstream unchanged as Type 1. It can become a special cycle. Or it can be ignored. The choice is made from the address word, the bus command and the two bus-number registers that the surrounding bridge supplies.

When the cycle targets the local bus, the block rebuilds the address for Type 0. The device number becomes a one-hot select line in the upper half of the address. Only sixteen such lines exist, so devices 16 and up get no select line, and the block predicts a master abort for them. The decision, the rebuilt address and the qualifier flags are all registered. They are captured on the edge where the frame-start strobe is high and are held until the next strobe.

Top module: `cfgx_translator`

## Requirements
- R1: A captured cycle whose command is neither configuration read (1010b) nor configuration write (1011b) gives decision IGNORE (code 0), an all-zero output address and all flags low.
- R2: A cycle is forwarded with decision PASS1 (code 2), and its address is copied unchanged, when all three hold: bits 1:0 of the address are 01b, the command is a configuration read or write, and the bus number (bits 23:16) is greater than the secondary bus number and at most the subordinate bus number. A bus number below the secondary number or above the subordinate number gives IGNORE.
- R3: A valid configuration cycle whose bus number equals the secondary bus number gives decision LOCAL0 (code 1). It does so unless R7 applies. In the rebuilt address, bits 1:0 are 00b and bits 15:11 are zero. The function field (bits 10:8) and the register field (bits 7:2) are copied from the input.
- R4: For LOCAL0 with device number d (bits 15:11) in 0..15, output address bits 31:16 are one-hot, with bit 16+d set.
- R5: For LOCAL0 with device number 16..30, or with device 31 and a nonzero register field, bits 31:16 are all zero. The decision is still LOCAL0.
- R6: The abort-prediction output is high exactly when the decision is LOCAL0 and no select line is set.
- R7: Device 31 with register field zero on the secondary bus gives decision SPECIAL (code 3) and an all-zero output address.
- R8: The single-beat and delayed-handling outputs are both high exactly when the decision is LOCAL0.
- R9: Outputs change only on an edge where the strobe is high. With the strobe low they hold, whatever the other inputs do.
- R10: A synchronous active-high reset sets the decision to IGNORE and clears the address and all flags.
- R11: A configuration cycle whose address bits 1:0 are not 01b gives IGNORE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Address-phase strobe; inputs are captured on this edge |
| ad_in | input | 32 | Address word of the incoming cycle |
| cmd_in | input | 4 | Bus command of the incoming cycle |
| sec_bus | input | 8 | Secondary bus number register |
| sub_bus | input | 8 | Subordinate bus number register |
| decision | output | 2 | 0 ignore, 1 local Type 0, 2 pass Type 1, 3 special cycle |
| ad_out | output | 32 | Translated address |
| abort_pred | output | 1 | Translated Type 0 cycle has no select line |
| single_beat | output | 1 | Cycle is limited to one 32-bit transfer |
| delayed_txn | output | 1 | Cycle must be handled as a delayed transaction |

## Verification
The hold and capture assertions assume that the bus-number registers and the address are stable at the capturing edge. They also assume that the subordinate number is at least the secondary number. The stimulus changes inputs only on the falling clock edge and uses bus-register pairs that satisfy this ordering. Device numbers are swept over every select line, the unselected range and device 31 with both zero and nonzero register fields. Bus numbers are placed just inside and just outside both ends of the forwarding window.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  typedef enum logic [1:0] {
    DEC_IGNORE  = 2'd0,
    DEC_LOCAL0  = 2'd1,
    DEC_PASS1   = 2'd2,
    DEC_SPECIAL = 2'd3
  } dec_e;

  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
  localparam logic [1:0] TYPE1_TAG  = 2'b01;

endpackage

// File: rtl/cfgx_classify.sv
module cfgx_classify
  import cfgx_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int REG_W = 6,
  localparam int REG_LSB = 2,
  localparam int FN_LSB  = REG_LSB + REG_W,
  localparam int DEV_LSB = FN_LSB + FN_W,
  localparam int BUS_LSB = DEV_LSB + DEV_W,
  localparam int IN_W    = BUS_LSB + BUS_W
) (
  input  logic [IN_W-1:0]  ad_lo,
  input  logic [3:0]       cmd,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  output dec_e             dec,
  output logic [DEV_W-1:0] dev,
  output logic [FN_W-1:0]  fn,
  output logic [REG_W-1:0] rg
);

  localparam logic [DEV_W-1:0] DEV_TOP = '1;

  logic [BUS_W-1:0] bus_n;
  logic             cfg_cmd;
  logic             type1_ok;
  logic             is_local;
  logic             in_window;
  logic             spec_hit;

  assign bus_n = ad_lo[BUS_LSB +: BUS_W];
  assign dev   = ad_lo[DEV_LSB +: DEV_W];
  assign fn    = ad_lo[FN_LSB +: FN_W];
  assign rg    = ad_lo[REG_LSB +: REG_W];

  assign cfg_cmd   = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
  assign type1_ok  = (ad_lo[1:0] == TYPE1_TAG);
  assign is_local  = (bus_n == sec_bus);
  assign in_window = (bus_n > sec_bus) && (bus_n <= sub_bus);
  assign spec_hit  = (dev == DEV_TOP) && (rg == '0);

  always_comb begin
    dec = DEC_IGNORE;
    if (cfg_cmd && type1_ok) begin
      if (is_local) begin
        dec = spec_hit ? DEC_SPECIAL : DEC_LOCAL0;
      end else if (in_window) begin
        dec = DEC_PASS1;
      end
    end
  end

  always_comb begin
    if (!cfg_cmd) assert (dec == DEC_IGNORE);  // R1
  end

endmodule

// File: rtl/cfgx_selgen.sv
module cfgx_selgen #(
  parameter int DEV_W = 5,
  parameter int SEL_N = 16
) (
  input  logic [DEV_W-1:0] dev,
  output logic [SEL_N-1:0] sel
);

  for (genvar i = 0; i < SEL_N; i++) begin : g_line
    assign sel[i] = (dev == DEV_W'(i));
  end

  always_comb begin
    assert ($onehot0(sel));  // R4
  end

endmodule

// File: rtl/cfgx_compose.sv
module cfgx_compose
  import cfgx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_N  = 16,
  parameter int FN_W   = 3,
  parameter int REG_W  = 6,
  localparam int REG_LSB = 2,
  localparam int FN_LSB  = REG_LSB + REG_W,
  localparam int SEL_LSB = ADDR_W - SEL_N
) (
  input  dec_e              dec,
  input  logic [ADDR_W-1:0] ad,
  input  logic [SEL_N-1:0]  sel,
  input  logic [FN_W-1:0]   fn,
  input  logic [REG_W-1:0]  rg,
  output logic [ADDR_W-1:0] ad_nxt,
  output logic              abort_nxt,
  output logic              beat_nxt
);

  always_comb begin
    ad_nxt = '0;
    unique case (dec)
      DEC_LOCAL0: begin
        ad_nxt[SEL_LSB +: SEL_N] = sel;
        ad_nxt[FN_LSB +: FN_W]   = fn;
        ad_nxt[REG_LSB +: REG_W] = rg;
      end
      DEC_PASS1: ad_nxt = ad;
      default:   ad_nxt = '0;
    endcase
  end

  assign beat_nxt  = (dec == DEC_LOCAL0);
  assign abort_nxt = beat_nxt && (sel == '0);

endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator
  import cfgx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FN_W   = 3,
  parameter int REG_W  = 6,
  parameter int SEL_N  = 16,
  localparam int IN_W    = 2 + REG_W + FN_W + DEV_W + BUS_W,
  localparam int SEL_LSB = ADDR_W - SEL_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic [3:0]        cmd_in,
  input  logic [BUS_W-1:0]  sec_bus,
  input  logic [BUS_W-1:0]  sub_bus,
  output logic [1:0]        decision,
  output logic [ADDR_W-1:0] ad_out,
  output logic              abort_pred,
  output logic              single_beat,
  output logic              delayed_txn
);

  dec_e              dec_c;
  logic [DEV_W-1:0]  dev_c;
  logic [FN_W-1:0]   fn_c;
  logic [REG_W-1:0]  rg_c;
  logic [SEL_N-1:0]  sel_c;
  logic [ADDR_W-1:0] ad_c;
  logic              abort_c;
  logic              beat_c;

  cfgx_classify #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .REG_W(REG_W)
  ) u_classify (
    .ad_lo  (ad_in[IN_W-1:0]),
    .cmd    (cmd_in),
    .sec_bus(sec_bus),
    .sub_bus(sub_bus),
    .dec    (dec_c),
    .dev    (dev_c),
    .fn     (fn_c),
    .rg     (rg_c)
  );

  cfgx_selgen #(
    .DEV_W(DEV_W), .SEL_N(SEL_N)
  ) u_selgen (
    .dev(dev_c),
    .sel(sel_c)
  );

  cfgx_compose #(
    .ADDR_W(ADDR_W), .SEL_N(SEL_N), .FN_W(FN_W), .REG_W(REG_W)
  ) u_compose (
    .dec      (dec_c),
    .ad       (ad_in),
    .sel      (sel_c),
    .fn       (fn_c),
    .rg       (rg_c),
    .ad_nxt   (ad_c),
    .abort_nxt(abort_c),
    .beat_nxt (beat_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      decision    <= DEC_IGNORE;
      ad_out      <= '0;
      abort_pred  <= 1'b0;
      single_beat <= 1'b0;
      delayed_txn <= 1'b0;
    end else if (frame_start) begin
      decision    <= dec_c;
      ad_out      <= ad_c;
      abort_pred  <= abort_c;
      single_beat <= beat_c;
      delayed_txn <= beat_c;
    end
  end

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(decision) && $stable(ad_out) && $stable(abort_pred)); // R9

  AST_NONCFG_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (frame_start && cmd_in != CMD_CFG_RD && cmd_in != CMD_CFG_WR) |=> decision == DEC_IGNORE); // R1

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    decision == DEC_LOCAL0 |-> $onehot0(ad_out[ADDR_W-1:SEL_LSB])); // R4

  AST_LOCAL_LOWBITS: assert property (@(posedge clk) disable iff (rst)
    decision == DEC_LOCAL0 |-> ad_out[1:0] == 2'b00); // R3

  AST_ABORT_NOSEL: assert property (@(posedge clk) disable iff (rst)
    abort_pred |-> (decision == DEC_LOCAL0 && ad_out[ADDR_W-1:SEL_LSB] == '0)); // R6

  AST_BEAT_LOCAL: assert property (@(posedge clk) disable iff (rst)
    (single_beat || delayed_txn) |-> decision == DEC_LOCAL0); // R8

  AST_SPECIAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    decision == DEC_SPECIAL |-> ad_out == '0); // R7

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (decision == DEC_IGNORE && ad_out == '0)); // R10

endmodule

// File: tb/cfgx_translator_test.sv
module cfgx_translator_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cmd_in = '0;
  logic [7:0]  sec_bus = '0;
  logic [7:0]  sub_bus = '0;
  logic [1:0]  decision;
  logic [31:0] ad_out;
  logic        abort_pred, single_beat, delayed_txn;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit chk_on = 1'b0;
  string cur_tag = "R10";
  string exp_tag = "R10";

  logic [1:0]  e_dec = 2'd0;
  logic [31:0] e_ad = '0;
  logic        e_abort = 1'b0, e_beat = 1'b0;

  cfgx_translator uut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .ad_in(ad_in),
    .cmd_in(cmd_in), .sec_bus(sec_bus), .sub_bus(sub_bus),
    .decision(decision), .ad_out(ad_out), .abort_pred(abort_pred),
    .single_beat(single_beat), .delayed_txn(delayed_txn)
  );

  always #2 clk = ~clk;

  // behavioural reference
  always @(posedge clk) begin
    int bus, dev, fn, rg;
    bus = int'(ad_in[23:16]);
    dev = int'(ad_in[15:11]);
    fn  = int'(ad_in[10:8]);
    rg  = int'(ad_in[7:2]);
    if (rst) begin
      e_dec <= 0; e_ad <= 0; e_abort <= 0; e_beat <= 0; exp_tag <= "R10";
    end else if (frame_start) begin
      exp_tag <= cur_tag;
      if (!(cmd_in == 4'hA || cmd_in == 4'hB) || ad_in[1:0] != 2'b01) begin
        e_dec <= 0; e_ad <= 0; e_abort <= 0; e_beat <= 0;
      end else if (bus == int'(sec_bus)) begin
        if (dev == 31 && rg == 0) begin
          e_dec <= 3; e_ad <= 0; e_abort <= 0; e_beat <= 0;
        end else begin
          logic [31:0] a;
          a = 0;
          if (dev < 16) a = 32'h1 << (16 + dev);
          a = a + (fn << 8) + (rg << 2);
          e_dec <= 1; e_ad <= a; e_abort <= (dev >= 16); e_beat <= 1;
        end
      end else if (bus > int'(sec_bus) && bus <= int'(sub_bus)) begin
        e_dec <= 2; e_ad <= ad_in; e_abort <= 0; e_beat <= 0;
      end else begin
        e_dec <= 0; e_ad <= 0; e_abort <= 0; e_beat <= 0;
      end
    end else begin
      exp_tag <= "R9";
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      n_chk++;
      if (decision !== e_dec || ad_out !== e_ad || abort_pred !== e_abort ||
          single_beat !== e_beat || delayed_txn !== e_beat) begin
        n_fail++;
        $display("FAIL %s: got dec=%0d ad=%h ab=%b sb=%b dt=%b exp dec=%0d ad=%h ab=%b sb=%b dt=%b",
                 exp_tag, decision, ad_out, abort_pred, single_beat, delayed_txn,
                 e_dec, e_ad, e_abort, e_beat, e_beat);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input int bus, input int dev, input int fn,
                                     input int rg, input logic [1:0] lo);
    return {8'hC3, 8'(bus), 5'(dev), 3'(fn), 6'(rg), lo};
  endfunction

  task automatic cyc(input logic [31:0] a, input logic [3:0] c, input logic s, input string tag);
    @(negedge clk);
    ad_in = a; cmd_in = c; frame_start = s; cur_tag = tag;
  endtask

  initial begin
    sec_bus = 8'h05; sub_bus = 8'h09;
    repeat (2) @(negedge clk);
    chk_on = 1'b1;                       // R10 reset state checked
    @(negedge clk); rst = 1'b0;
    for (int d = 0; d < 16; d++) cyc(mk(5, d, d % 8, d * 3, 2'b01), 4'hA, 1, "R4");
    for (int d = 16; d < 31; d++) cyc(mk(5, d, 2, 9, 2'b01), 4'hB, 1, "R5");
    cyc(mk(5, 31, 1, 0, 2'b01), 4'hA, 1, "R7");
    cyc(mk(5, 31, 1, 4, 2'b01), 4'hA, 1, "R6");
    cyc(mk(5, 3, 7, 63, 2'b01), 4'hB, 1, "R3");
    cyc(mk(6, 3, 1, 1, 2'b01), 4'hA, 1, "R2");
    cyc(mk(9, 4, 1, 1, 2'b01), 4'hB, 1, "R2");
    cyc(mk(10, 4, 1, 1, 2'b01), 4'hA, 1, "R2");
    cyc(mk(4, 4, 1, 1, 2'b01), 4'hA, 1, "R2");
    for (int c = 0; c < 16; c++) cyc(mk(5, 2, 0, 5, 2'b01), 4'(c), 1, "R1");
    cyc(mk(5, 2, 0, 5, 2'b00), 4'hA, 1, "R11");
    cyc(mk(7, 2, 0, 5, 2'b11), 4'hA, 1, "R11");
    cyc(mk(7, 2, 0, 5, 2'b10), 4'hB, 1, "R11");
    cyc(mk(5, 1, 2, 3, 2'b01), 4'hA, 1, "R8");
    for (int k = 0; k < 6; k++) cyc(mk(5 + k, k, 0, 1, 2'b01), 4'hB, 0, "R9");
    cyc(mk(5, 3, 2, 3, 2'b01), 4'hA, 1, "R8");
    @(negedge clk); rst = 1'b1; frame_start = 1'b1; cur_tag = "R10";
    @(negedge clk); rst = 1'b0;
    sec_bus = 8'h00; sub_bus = 8'hFF;
    cyc(mk(0, 15, 7, 1, 2'b01), 4'hA, 1, "R4");
    cyc(mk(255, 0, 0, 0, 2'b01), 4'hA, 1, "R2");
    cyc(mk(1, 31, 0, 0, 2'b01), 4'hB, 1, "R2");
    cyc(mk(0, 31, 0, 0, 2'b01), 4'hB, 1, "R7");
    cyc(mk(0, 0, 0, 0, 2'b01), 4'hB, 0, "R9");
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule